// File: doc/BRIEF.md
# Subsystem Energy Sum Processor

This block gathers per-crate partial results from up to eight parallel input links. Each link delivers a data word, a timestamp and a valid flag. A word that arrives on a link waits in that link's own queue until every enabled link holds a word at its head. The block then checks that all those head timestamps agree. If they do, it forms one subsystem total for that sample period and sends it as a time-stamped report to every downstream global trigger processor. A new total can leave on every clock cycle, so a stream that delivers one word per link per cycle gets one report per cycle.

A mode input selects the kind of total. In energy mode the data words are added. In hit mode each enabled link adds one when its word is non-zero. A per-link enable mask takes crates out of the sum. When a large subsystem is split across two boards, a partial-result input marks each report as a partial total and tags it with the board's identity, so that the global stage can combine the two halves. If the timestamps at the heads of the queues disagree, the block drops that period's report and raises an error flag that stays set until reset.

Top module: `sep_sum_processor`

## Requirements
- R1: After a synchronous active-low reset, no report is valid and `ts_err` is 0. Reset also clears every link queue.
- R2: In energy mode (`hit_mode`=0) a report's sum is the unsigned total of the head words of all enabled links. The report is valid in the cycle after the clock edge that follows the capture of the last required word.
- R3: In hit mode (`hit_mode`=1) each enabled link adds 1 if its head word is non-zero and 0 otherwise.
- R4: A link whose bit in `link_mask` is 0 contributes nothing to any report. Its valid, data and timestamp inputs are ignored, and its queue is emptied.
- R5: If the head timestamps of the enabled links differ, no report is issued for that set of heads, the heads are discarded, and `ts_err` becomes 1 and stays 1 until reset.
- R6: A total above 2^OW-1 is reported as 2^OW-1. A total that equals 2^OW-1 is reported exactly.
- R7: Each link queue holds up to FIFO_DEPTH (16) words, so a link may run up to 16 words ahead of the others without any loss of data or alignment.
- R8: A report's timestamp equals the common timestamp of the words it was built from.
- R9: Each report is presented identically, in the same cycle, on all NGTP output slots. Slot g occupies bits [g*W +: W] of each output bus.
- R10: A report carries `rpt_partial` equal to `partial_mode` and `rpt_board` equal to `board_id`, both sampled in the cycle the report is formed.
- R11: When `link_mask` is all zeros, no report is ever issued.
- R12: When every enabled link delivers one matching word per cycle, one report is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lnk_valid | input | NLINK | Per-link word valid |
| lnk_data | input | NLINK*DW | Per-link data word; link i at [i*DW +: DW] |
| lnk_ts | input | NLINK*TSW | Per-link timestamp; link i at [i*TSW +: TSW] |
| link_mask | input | NLINK | 1 enables a link |
| hit_mode | input | 1 | 0 sums energies, 1 counts hits |
| partial_mode | input | 1 | 1 marks reports as partial totals |
| board_id | input | 1 | Identity of this board in a split pair |
| rpt_valid | output | NGTP | Report valid per global processor slot |
| rpt_sum | output | NGTP*OW | Report total per slot |
| rpt_ts | output | NGTP*TSW | Report timestamp per slot |
| rpt_partial | output | NGTP | Partial-result flag per slot |
| rpt_board | output | NGTP | Board identity per slot |
| ts_err | output | 1 | Sticky timestamp mismatch flag |

## Verification
The bench targets four kinds of corner case.

- **Skew.** One link runs a full queue of sixteen words ahead of the others. A design that lost the last entry, or that aligned words by arrival order, would emit wrong sums or too few reports.
- **Saturation.** Totals are driven just at and above the output maximum. A wrapping adder would report a small value.
- **Masked links.** Disabled links carry garbage words and mismatched timestamps. A design that still read them would corrupt the sum or raise a false error.
- **Timestamp mismatch.** A single-link mismatch is followed by good data. A design that reported the bad period, stalled, or cleared the flag would show up in the per-cycle comparison against the behavioural model.

// File: rtl/sep_pkg.sv
// Shared types and helpers for the subsystem sum processor.
package sep_pkg;
    // Selects what each enabled link contributes to the total.
    typedef enum logic {
        SUM_ENERGY = 1'b0,
        SUM_HITS   = 1'b1
    } sum_mode_e;
endpackage

// File: rtl/sep_link_fifo.sv
// Per-link skew queue.
// Holds words of one input link until the aligner consumes them.
// Assumes pop is only raised while the queue is non-empty. A push while
// full is accepted only if a pop happens in the same cycle; otherwise the
// new word is dropped. A flush empties the queue.
module sep_link_fifo #(
    parameter int W     = 24,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   cnt;
    logic          push_ok;
    logic          pop_ok;

    assign pop_ok  = pop && (cnt != '0);
    assign push_ok = push && ((32'(cnt) != DEPTH) || pop_ok);
    assign empty   = (cnt == '0);
    assign dout    = mem[rd_ptr];

    // Purpose: advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            cnt <= cnt + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
        end
    end

    // Purpose: store an accepted word.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end
endmodule

// File: rtl/sep_align_sum.sv
// Timestamp aligner and saturating adder (combinational).
// Declares the heads ready when every enabled queue is non-empty.
// Compares every enabled head timestamp with the first enabled one.
// Forms the total in the selected mode, clamped to the output width.
// Assumes the output width is no wider than the internal accumulator.
module sep_align_sum
    import sep_pkg::*;
#(
    parameter int NLINK = 8,
    parameter int DW    = 16,
    parameter int TSW   = 8,
    parameter int OW    = 16
) (
    input  logic [NLINK-1:0]     mask,
    input  logic [NLINK-1:0]     empty,
    input  logic [NLINK*DW-1:0]  head_data,
    input  logic [NLINK*TSW-1:0] head_ts,
    input  sum_mode_e            mode,
    output logic                 ready,
    output logic                 match,
    output logic [OW-1:0]        sum,
    output logic [TSW-1:0]       ts_ref
);
    localparam int ACCW = ((DW > OW) ? DW : OW) + $clog2(NLINK) + 1;
    localparam logic [ACCW-1:0] MAXO = ACCW'({OW{1'b1}});

    logic [ACCW-1:0] acc;
    logic            found;

    // Purpose: readiness, timestamp agreement and the raw total.
    always_comb begin
        ready  = |mask;
        match  = 1'b1;
        found  = 1'b0;
        ts_ref = '0;
        acc    = '0;
        for (int i = 0; i < NLINK; i++) begin
            if (mask[i]) begin
                if (empty[i]) ready = 1'b0;
                if (!found) begin
                    ts_ref = head_ts[i*TSW +: TSW];
                    found  = 1'b1;
                end else if (head_ts[i*TSW +: TSW] != ts_ref) begin
                    match = 1'b0;
                end
                if (mode == SUM_HITS)
                    acc = acc + ACCW'(head_data[i*DW +: DW] != '0);
                else
                    acc = acc + ACCW'(head_data[i*DW +: DW]);
            end
        end
    end

    // Purpose: clamp the total to the largest output word.
    always_comb begin
        sum = (acc > MAXO) ? {OW{1'b1}} : acc[OW-1:0];
    end
endmodule

// File: rtl/sep_sum_processor.sv
// Subsystem sum processor top.
// Queues each enabled link's words and pops all enabled heads together.
// Registers one report when their timestamps agree. Raises a sticky error
// and skips the report when they disagree. Fans the report out to NGTP
// downstream slots. Assumes the link inputs are synchronous to clk.
module sep_sum_processor
    import sep_pkg::*;
#(
    parameter int NLINK      = 8,
    parameter int DW         = 16,
    parameter int TSW        = 8,
    parameter int OW         = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int NGTP       = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NLINK-1:0]     lnk_valid,
    input  logic [NLINK*DW-1:0]  lnk_data,
    input  logic [NLINK*TSW-1:0] lnk_ts,
    input  logic [NLINK-1:0]     link_mask,
    input  logic                 hit_mode,
    input  logic                 partial_mode,
    input  logic                 board_id,
    output logic [NGTP-1:0]      rpt_valid,
    output logic [NGTP*OW-1:0]   rpt_sum,
    output logic [NGTP*TSW-1:0]  rpt_ts,
    output logic [NGTP-1:0]      rpt_partial,
    output logic [NGTP-1:0]      rpt_board,
    output logic                 ts_err
);
    localparam int EW = TSW + DW;

    logic [NLINK-1:0]     q_empty;
    logic [NLINK-1:0]     q_pop;
    logic [NLINK*DW-1:0]  q_data;
    logic [NLINK*TSW-1:0] q_ts;
    logic                 al_ready;
    logic                 al_match;
    logic [OW-1:0]        al_sum;
    logic [TSW-1:0]       al_ts;

    logic                 r_vld;
    logic [OW-1:0]        r_sum;
    logic [TSW-1:0]       r_ts;
    logic                 r_part;
    logic                 r_board;
    logic                 r_err;

    // One skew queue per link; a disabled link is held flushed.
    for (genvar i = 0; i < NLINK; i++) begin : g_link
        logic [EW-1:0] head;

        sep_link_fifo #(.W(EW), .DEPTH(FIFO_DEPTH)) fifo_i (
            .clk   (clk),
            .rst_n (rst_n),
            .flush (!link_mask[i]),
            .push  (lnk_valid[i] && link_mask[i]),
            .din   ({lnk_ts[i*TSW +: TSW], lnk_data[i*DW +: DW]}),
            .pop   (q_pop[i]),
            .dout  (head),
            .empty (q_empty[i])
        );

        assign q_ts[i*TSW +: TSW] = head[EW-1:DW];
        assign q_data[i*DW +: DW] = head[DW-1:0];
    end

    sep_align_sum #(.NLINK(NLINK), .DW(DW), .TSW(TSW), .OW(OW)) align_i (
        .mask      (link_mask),
        .empty     (q_empty),
        .head_data (q_data),
        .head_ts   (q_ts),
        .mode      (sum_mode_e'(hit_mode)),
        .ready     (al_ready),
        .match     (al_match),
        .sum       (al_sum),
        .ts_ref    (al_ts)
    );

    // Every enabled head is consumed once all are present, match or not.
    assign q_pop = al_ready ? link_mask : '0;

    // Purpose: register the report and the sticky mismatch flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_vld   <= 1'b0;
            r_sum   <= '0;
            r_ts    <= '0;
            r_part  <= 1'b0;
            r_board <= 1'b0;
            r_err   <= 1'b0;
        end else begin
            r_vld <= al_ready && al_match;
            if (al_ready && al_match) begin
                r_sum   <= al_sum;
                r_ts    <= al_ts;
                r_part  <= partial_mode;
                r_board <= board_id;
            end
            if (al_ready && !al_match) r_err <= 1'b1;
        end
    end

    // Identical copy of the report for each downstream processor.
    for (genvar g = 0; g < NGTP; g++) begin : g_fanout
        assign rpt_valid[g]           = r_vld;
        assign rpt_sum[g*OW +: OW]    = r_sum;
        assign rpt_ts[g*TSW +: TSW]   = r_ts;
        assign rpt_partial[g]         = r_part;
        assign rpt_board[g]           = r_board;
    end

    assign ts_err = r_err;
endmodule

// File: rtl/sep_sum_checker.sv
// Property checker for the subsystem sum processor, bound to its top.
// Observes only top-level ports; assumes the synchronous active-low reset.
module sep_sum_checker #(
    parameter int NLINK = 8,
    parameter int OW    = 16,
    parameter int NGTP  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NLINK-1:0] link_mask,
    input logic             hit_mode,
    input logic [NGTP-1:0]  rpt_valid,
    input logic [OW-1:0]    rpt_sum0,
    input logic             ts_err
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!rpt_valid[0] && !ts_err));                              // R1

    AST_HIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        hit_mode |=> (!rpt_valid[0] || (rpt_sum0 <= OW'(NLINK))));           // R3

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ts_err |=> ts_err);                                                  // R5

    AST_ERR_SKIPS_REPORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ts_err) |-> !rpt_valid[0]);                                    // R5

    AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (link_mask == '0) |=> !rpt_valid[0]);                                // R11
endmodule

bind sep_sum_processor sep_sum_checker #(
    .NLINK (NLINK),
    .OW    (OW),
    .NGTP  (NGTP)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_mask (link_mask),
    .hit_mode  (hit_mode),
    .rpt_valid (rpt_valid),
    .rpt_sum0  (rpt_sum[OW-1:0]),
    .ts_err    (ts_err)
);

// File: tb/sep_sum_processor_tb_top.sv
// Bench: a behavioural queue model is compared with the design every cycle,
// and directed checks are made at the end of each scenario.
module sep_sum_processor_tb_top;
    localparam int NLINK = 8;
    localparam int DW    = 16;
    localparam int TSW   = 8;
    localparam int OW    = 16;
    localparam int DEPTH = 16;
    localparam int NGTP  = 2;
    localparam longint MAXO = (64'd1 << OW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NLINK-1:0]     lnk_valid = '0;
    logic [NLINK*DW-1:0]  lnk_data = '0;
    logic [NLINK*TSW-1:0] lnk_ts = '0;
    logic [NLINK-1:0]     link_mask = '1;
    logic                 hit_mode = 1'b0;
    logic                 partial_mode = 1'b0;
    logic                 board_id = 1'b0;
    logic [NGTP-1:0]      rpt_valid;
    logic [NGTP*OW-1:0]   rpt_sum;
    logic [NGTP*TSW-1:0]  rpt_ts;
    logic [NGTP-1:0]      rpt_partial;
    logic [NGTP-1:0]      rpt_board;
    logic                 ts_err;

    sep_sum_processor #(
        .NLINK(NLINK), .DW(DW), .TSW(TSW), .OW(OW),
        .FIFO_DEPTH(DEPTH), .NGTP(NGTP)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .lnk_valid(lnk_valid), .lnk_data(lnk_data),
        .lnk_ts(lnk_ts), .link_mask(link_mask), .hit_mode(hit_mode),
        .partial_mode(partial_mode), .board_id(board_id),
        .rpt_valid(rpt_valid), .rpt_sum(rpt_sum), .rpt_ts(rpt_ts),
        .rpt_partial(rpt_partial), .rpt_board(rpt_board), .ts_err(ts_err)
    );

    always #5 clk = ~clk;

    int     n_total = 0;
    int     n_fail  = 0;
    int     n_seen  = 0;
    int     cyc     = 0;
    bit     armed   = 0;
    bit     done    = 0;
    string  cur_req = "R1";

    int     dv [NLINK];
    int     tv [NLINK];

    // Behavioural model state.
    int unsigned qd [NLINK][$];
    int unsigned qt [NLINK][$];
    bit          exp_vld = 0;
    longint      exp_sum = 0;
    int          exp_ts  = 0;
    bit          exp_part = 0;
    bit          exp_board = 0;
    bit          exp_err = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    endtask

    // Model: evaluate the queues as they stand, then pop, then push.
    always @(posedge clk) begin
        bit rdy, mt, first;
        longint tot;
        int rts;
        armed = 1;
        cyc++;
        if (!rst_n) begin
            for (int i = 0; i < NLINK; i++) begin qd[i].delete(); qt[i].delete(); end
            exp_vld = 0;
            exp_err = 0;
        end else begin
            rdy = (link_mask != '0);
            for (int i = 0; i < NLINK; i++)
                if (link_mask[i] && qd[i].size() == 0) rdy = 0;
            exp_vld = 0;
            if (rdy) begin
                first = 1; mt = 1; tot = 0; rts = 0;
                for (int i = 0; i < NLINK; i++) begin
                    if (link_mask[i]) begin
                        if (first) begin rts = int'(qt[i][0]); first = 0; end
                        else if (int'(qt[i][0]) != rts) mt = 0;
                        if (hit_mode) tot += (qd[i][0] != 0) ? 1 : 0;
                        else          tot += qd[i][0];
                    end
                end
                if (mt) begin
                    exp_vld   = 1;
                    exp_sum   = (tot > MAXO) ? MAXO : tot;
                    exp_ts    = rts;
                    exp_part  = partial_mode;
                    exp_board = board_id;
                end else begin
                    exp_err = 1;
                end
                for (int i = 0; i < NLINK; i++)
                    if (link_mask[i]) begin void'(qd[i].pop_front()); void'(qt[i].pop_front()); end
            end
            for (int i = 0; i < NLINK; i++) begin
                if (!link_mask[i]) begin
                    qd[i].delete(); qt[i].delete();
                end else if (lnk_valid[i] && qd[i].size() < DEPTH) begin
                    qd[i].push_back(int'(lnk_data[i*DW +: DW]));
                    qt[i].push_back(int'(lnk_ts[i*TSW +: TSW]));
                end
            end
        end
        if (cyc > 20000 && !done) begin
            check(0, "watchdog", "cycles", cyc, 20000);
            finish_run();
        end
    end

    // Per-cycle comparison of the design's ports with the model (R9 for all slots).
    always @(negedge clk) begin
        if (armed && !done && rst_n) begin
            check(rpt_valid == (exp_vld ? {NGTP{1'b1}} : {NGTP{1'b0}}), cur_req,
                  "rpt_valid", longint'(rpt_valid), exp_vld ? longint'((1 << NGTP) - 1) : 0);
            check(ts_err == exp_err, cur_req, "ts_err", longint'(ts_err), longint'(exp_err));
            if (exp_vld) begin
                for (int g = 0; g < NGTP; g++) begin
                    check(longint'(rpt_sum[g*OW +: OW]) == exp_sum, cur_req, "rpt_sum",
                          longint'(rpt_sum[g*OW +: OW]), exp_sum);
                    check(int'(rpt_ts[g*TSW +: TSW]) == exp_ts, cur_req, "rpt_ts R8",
                          longint'(rpt_ts[g*TSW +: TSW]), longint'(exp_ts));
                    check({rpt_partial[g], rpt_board[g]} == {exp_part, exp_board}, cur_req,
                          "partial/board", longint'({rpt_partial[g], rpt_board[g]}),
                          longint'({exp_part, exp_board}));
                end
            end
            if (rpt_valid[0]) n_seen++;
        end
    end

    // Drive one cycle of link words from dv/tv for the links in v.
    task automatic drive(input logic [NLINK-1:0] v);
        for (int i = 0; i < NLINK; i++) begin
            lnk_data[i*DW +: DW] = DW'(dv[i]);
            lnk_ts[i*TSW +: TSW] = TSW'(tv[i]);
        end
        lnk_valid = v;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        lnk_valid = '0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int base;
        @(negedge clk); @(negedge clk); @(negedge clk);
        // R1: reset state
        check(rpt_valid == '0, "R1", "rpt_valid in reset", longint'(rpt_valid), 0);
        check(ts_err == 1'b0, "R1", "ts_err in reset", longint'(ts_err), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R8 / R9: energy sums, all links aligned
        cur_req = "R2";
        for (int k = 1; k <= 4; k++) begin
            for (int i = 0; i < NLINK; i++) begin dv[i] = 100 * k + 7 * i; tv[i] = k; end
            drive('1);
        end
        idle(3);

        // R7: link 0 runs sixteen words ahead
        cur_req = "R7";
        base = n_seen;
        for (int w = 0; w < DEPTH; w++) begin
            for (int i = 0; i < NLINK; i++) begin dv[i] = w + 1 + i; tv[i] = 20 + w; end
            drive(8'h01);
        end
        for (int w = 0; w < DEPTH; w++) begin
            for (int i = 0; i < NLINK; i++) begin dv[i] = 3 * w + i; tv[i] = 20 + w; end
            drive(8'hFE);
        end
        idle(3);
        check(n_seen - base == DEPTH, "R7", "reports after skew", n_seen - base, DEPTH);

        // R3: hit counting with some zero words
        cur_req = "R3";
        hit_mode = 1'b1;
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NLINK; i++) begin dv[i] = ((i + k) % 3 == 0) ? 0 : 500 + i; tv[i] = 40 + k; end
            drive('1);
        end
        idle(3);
        hit_mode = 1'b0;

        // R4: disabled links carry garbage and wrong timestamps
        cur_req = "R4";
        link_mask = 8'hA5;
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < NLINK; i++) begin
                dv[i] = link_mask[i] ? 10 + i : 16'hDEAD;
                tv[i] = link_mask[i] ? 50 + k : 99;
            end
            drive('1);
        end
        idle(3);
        check(ts_err == 1'b0, "R4", "ts_err after masked garbage", longint'(ts_err), 0);
        link_mask = '1;
        @(negedge clk);

        // R6: saturation and exact maximum
        cur_req = "R6";
        for (int i = 0; i < NLINK; i++) begin dv[i] = 16'hFFFF; tv[i] = 60; end
        drive('1);
        for (int i = 0; i < NLINK; i++) begin dv[i] = (i == 2) ? 16'hFFFF : 0; tv[i] = 61; end
        drive('1);
        for (int i = 0; i < NLINK; i++) begin dv[i] = (i < 2) ? 16'h8000 : 0; tv[i] = 62; end
        drive('1);
        idle(3);

        // R11: all links masked, no report
        cur_req = "R11";
        link_mask = '0;
        base = n_seen;
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < NLINK; i++) begin dv[i] = 1 + i; tv[i] = 70; end
            drive('1);
        end
        idle(3);
        check(n_seen == base, "R11", "reports with empty mask", n_seen - base, 0);
        link_mask = '1;
        @(negedge clk);

        // R12: one report per cycle under streaming
        cur_req = "R12";
        base = n_seen;
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < NLINK; i++) begin dv[i] = k * 11 + i; tv[i] = k; end
            drive('1);
        end
        idle(3);
        check(n_seen - base == 40, "R12", "streamed reports", n_seen - base, 40);

        // R10: partial result tagging
        cur_req = "R10";
        partial_mode = 1'b1;
        board_id = 1'b1;
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < NLINK; i++) begin dv[i] = 200 + i; tv[i] = 80 + k; end
            drive('1);
        end
        board_id = 1'b0;
        for (int i = 0; i < NLINK; i++) begin dv[i] = 5; tv[i] = 82; end
        drive('1);
        idle(3);
        partial_mode = 1'b0;

        // R5: timestamp mismatch, then good data
        cur_req = "R5";
        base = n_seen;
        for (int i = 0; i < NLINK; i++) begin dv[i] = 9; tv[i] = (i == 3) ? 91 : 90; end
        drive('1);
        idle(3);
        check(ts_err == 1'b1, "R5", "ts_err after mismatch", longint'(ts_err), 1);
        check(n_seen == base, "R5", "report skipped", n_seen - base, 0);
        for (int i = 0; i < NLINK; i++) begin dv[i] = 4; tv[i] = 92; end
        drive('1);
        idle(3);
        check(ts_err == 1'b1, "R5", "ts_err stays set", longint'(ts_err), 1);
        check(n_seen - base == 1, "R5", "report after mismatch", n_seen - base, 1);

        // R1: reset clears the sticky flag
        cur_req = "R1";
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ts_err == 1'b0, "R1", "ts_err after reset", longint'(ts_err), 0);
        check(rpt_valid == '0, "R1", "rpt_valid after reset", longint'(rpt_valid), 0);
        finish_run();
    end
endmodule